// File: doc/BRIEF.md
# Persistent Page Integrity Classifier

At restart, each stored page must be classified before recovery can start. This block takes one page at a time as a stream of 64-bit words over a valid/ready handshake. The first three words form the header. The block recomputes a CRC64 over the whole page, counting the stored checksum word as zero, and compares the result with the checksum stored in the header. It also checks the header's identifying constant. If both pass, it compares the page's stored log sequence number with the value the host expects.

From these tests the page falls into one of four recovery classes, and each class has a fixed repair action. The result appears with a one-cycle completion pulse and stays on the outputs until the next page completes. Pages can follow one another directly. The checksum state is restarted for every page, so nothing carries over between pages.

Top module: `pic_page_classifier`

## Requirements
- R1: After synchronous active-high reset, `done` is 0, `in_ready` is 1, and `page_class`, `repair_action` and `crc_ok` are all 0.
- R2: A word is taken only on a rising edge where both `in_valid` and `in_ready` are 1. Words presented while `in_valid` is 0 have no effect. `in_ready` is 0 exactly in the cycles where `done` is 1, and 1 in all other cycles.
- R3: A page is `PAGE_WORDS` words long (default 8, minimum 4). Word 0 carries the identifying constant in bits 63:32 and flags in bits 31:0. Word 1 is the stored sequence number, as a 64-bit unsigned value. Word 2 is the stored checksum.
- R4: The recomputed checksum uses the generator 0x42F0E1EBA9EA3693 with an all-ones start value and no final inversion. It shifts in each word from bit 63 down to bit 0, in word order, with word 2 replaced by zero. The start value is reloaded at word 0 of every page. `crc_ok` is 1 when the result equals word 2.
- R5: When the recomputed checksum differs from the stored one, `page_class` is 3 (corrupted) and `repair_action` is 2 (fetch from disk, then replay).
- R6: When bits 63:32 of word 0 differ from the `MAGIC` parameter, the page is class 3 with action 2, even if the checksum matches.
- R7: When the checksum and constant are good and the stored sequence number is below the expected one (unsigned), the class is 1 (behind) with action 1 (replay the log).
- R8: When the checksum and constant are good and the two sequence numbers are equal, the class is 0 (current) with action 0 (none).
- R9: When the checksum and constant are good and the stored sequence number is above the expected one, the class is 2 (ahead) with action 2.
- R10: `done` is 1 for exactly one cycle: the cycle after the last word of a page is taken. The result outputs change only at that edge and hold their value until the next page completes.
- R11: The flag bits of word 0 affect only the checksum and have no other effect on the result.
- R12: `expected_lsn` is sampled only on the edge that takes the last word of a page. Its value at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Page word present |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 64 | Page word |
| expected_lsn | input | 64 | Sequence number the host expects; sampled with the last word |
| done | output | 1 | One-cycle pulse when a result is ready |
| page_class | output | 2 | 0 current, 1 behind, 2 ahead, 3 corrupted |
| repair_action | output | 2 | 0 none, 1 replay, 2 fetch then replay |
| crc_ok | output | 1 | Recomputed checksum matched the stored checksum |

## Verification
A fault in the checksum register or the word counter shows up at the very next `done`. A miscounted page either moves the pulse off the cycle that follows the last word, or changes `crc_ok` and turns a good page into class 3. A fault in the captured header fields shows up in the same pulse as a wrong class among 0, 1 and 2. These faults appear one page after they occur, never later. The sweep therefore covers many pages of each kind, sequence-number pairs at the unsigned limits, and pages sent back to back, so that a single stale bit of state cannot go unseen.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int          WORD_W       = 64;
    localparam int          MAGIC_W      = 32;
    localparam int          HDR_WORDS    = 3;
    localparam int          IDX_MAGIC    = 0;
    localparam int          IDX_LSN      = 1;
    localparam int          IDX_CSUM     = 2;
    localparam logic [63:0] CRC_GEN      = 64'h42F0_E1EB_A9EA_3693;
    localparam logic [63:0] CRC_SEED     = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef enum logic [1:0] {
        CLS_CURRENT = 2'd0,
        CLS_BEHIND  = 2'd1,
        CLS_AHEAD   = 2'd2,
        CLS_CORRUPT = 2'd3
    } page_class_e;

    typedef enum logic [1:0] {
        ACT_NONE         = 2'd0,
        ACT_REPLAY       = 2'd1,
        ACT_FETCH_REPLAY = 2'd2,
        ACT_RSVD         = 2'd3
    } repair_act_e;

    typedef struct packed {
        logic [MAGIC_W-1:0] magic;
        logic [WORD_W-1:0]  lsn;
        logic [WORD_W-1:0]  csum;
    } page_hdr_t;

    typedef struct packed {
        page_class_e cls;
        repair_act_e act;
        logic        crc_ok;
    } verdict_t;

    // Advance the checksum by one 64-bit word, most significant bit first.
    function automatic logic [63:0] crc_fold_word(input logic [63:0] crc_in,
                                                  input logic [63:0] word);
        logic [63:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 63; b >= 0; b--) begin
            fb = c[63] ^ word[b];
            c  = {c[62:0], 1'b0};
            if (fb) c = c ^ CRC_GEN;
        end
        return c;
    endfunction

    function automatic repair_act_e action_for(input page_class_e cls);
        case (cls)
            CLS_CURRENT: return ACT_NONE;
            CLS_BEHIND:  return ACT_REPLAY;
            default:     return ACT_FETCH_REPLAY;
        endcase
    endfunction

endpackage

// File: rtl/pic_word_seq.sv
module pic_word_seq #(
    parameter int PAGE_WORDS = 8,
    localparam int IDX_W = $clog2(PAGE_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    output logic [IDX_W-1:0] idx,
    output logic             first,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_WORDS - 1);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    assign idx   = idx_q;
    assign first = (idx_q == '0);
    assign last  = (idx_q == LAST_IDX);

    p_idx_in_page_r3: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST_IDX);

    p_wrap_after_last_r3: assert property (@(posedge clk) disable iff (rst)
        (take && last) |=> (idx_q == '0));

endmodule

// File: rtl/pic_crc_engine.sv
module pic_crc_engine
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              first,
    input  logic              mask_word,
    input  logic [WORD_W-1:0] word,
    output logic [63:0]       crc_next
);
    logic [63:0] crc_q;
    logic [63:0] base;
    logic [63:0] eff_word;

    always_comb begin
        base     = first ? CRC_SEED : crc_q;
        eff_word = mask_word ? '0 : word;
        crc_next = crc_fold_word(base, eff_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_SEED;
        end else if (take) begin
            crc_q <= crc_next;
        end
    end

    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(crc_q));

endmodule

// File: rtl/pic_hdr_capture.sv
module pic_hdr_capture
    import pic_pkg::*;
#(
    parameter int PAGE_WORDS = 8,
    localparam int IDX_W = $clog2(PAGE_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] word,
    output page_hdr_t         hdr
);
    page_hdr_t hdr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
        end else if (take) begin
            case (idx)
                IDX_W'(IDX_MAGIC): hdr_q.magic <= word[63:32];
                IDX_W'(IDX_LSN):   hdr_q.lsn   <= word;
                IDX_W'(IDX_CSUM):  hdr_q.csum  <= word;
                default: ;
            endcase
        end
    end

    assign hdr = hdr_q;

    p_body_keeps_header_r3: assert property (@(posedge clk) disable iff (rst)
        (take && idx >= IDX_W'(HDR_WORDS)) |=> $stable(hdr_q));

endmodule

// File: rtl/pic_verdict.sv
module pic_verdict
    import pic_pkg::*;
(
    input  logic              magic_ok,
    input  logic              crc_match,
    input  logic [WORD_W-1:0] stored_lsn,
    input  logic [WORD_W-1:0] expect_lsn,
    output verdict_t          verdict
);
    page_class_e cls;

    always_comb begin
        if (!crc_match || !magic_ok) begin
            cls = CLS_CORRUPT;
        end else if (stored_lsn < expect_lsn) begin
            cls = CLS_BEHIND;
        end else if (stored_lsn == expect_lsn) begin
            cls = CLS_CURRENT;
        end else begin
            cls = CLS_AHEAD;
        end
        verdict.cls    = cls;
        verdict.act    = action_for(cls);
        verdict.crc_ok = crc_match;
    end

endmodule

// File: rtl/pic_page_classifier.sv
module pic_page_classifier
    import pic_pkg::*;
#(
    parameter int          PAGE_WORDS = 8,
    parameter logic [31:0] MAGIC      = 32'hC0DE_5A9E
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [63:0] in_data,
    input  logic [63:0] expected_lsn,
    output logic        done,
    output logic [1:0]  page_class,
    output logic [1:0]  repair_action,
    output logic        crc_ok
);
    localparam int IDX_W = $clog2(PAGE_WORDS);

    logic             take;
    logic [IDX_W-1:0] idx;
    logic             first;
    logic             last;
    logic [63:0]      crc_next;
    page_hdr_t        hdr;
    verdict_t         verdict;
    verdict_t         result_q;
    logic             done_q;

    assign in_ready = !done_q;
    assign take     = in_valid && in_ready;

    pic_word_seq #(.PAGE_WORDS(PAGE_WORDS)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .idx   (idx),
        .first (first),
        .last  (last)
    );

    pic_crc_engine u_crc (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .first     (first),
        .mask_word (idx == IDX_W'(IDX_CSUM)),
        .word      (in_data),
        .crc_next  (crc_next)
    );

    pic_hdr_capture #(.PAGE_WORDS(PAGE_WORDS)) u_hdr (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .idx  (idx),
        .word (in_data),
        .hdr  (hdr)
    );

    pic_verdict u_verdict (
        .magic_ok   (hdr.magic == MAGIC),
        .crc_match  (crc_next == hdr.csum),
        .stored_lsn (hdr.lsn),
        .expect_lsn (expected_lsn),
        .verdict    (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q   <= 1'b0;
            result_q <= '{cls: CLS_CURRENT, act: ACT_NONE, crc_ok: 1'b0};
        end else begin
            done_q <= take && last;
            if (take && last) begin
                result_q <= verdict;
            end
        end
    end

    assign done          = done_q;
    assign page_class    = result_q.cls;
    assign repair_action = result_q.act;
    assign crc_ok        = result_q.crc_ok;

    p_done_follows_last_r10: assert property (@(posedge clk) disable iff (rst)
        (take && last) |=> done);

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_ready_drops_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    p_result_held_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(page_class) && $stable(repair_action) && $stable(crc_ok)));

    p_bad_crc_corrupt_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !crc_ok) |-> (page_class == 2'd3 && repair_action == 2'd2));

    p_current_no_action_r8: assert property (@(posedge clk) disable iff (rst)
        (done && page_class == 2'd0) |-> (repair_action == 2'd0 && crc_ok));

    initial begin
        a_min_page_r3: assert (PAGE_WORDS >= HDR_WORDS + 1);
    end

endmodule

// File: tb/sim_pic_page_classifier.sv
module sim_pic_page_classifier;

    localparam int          PW      = 8;
    localparam logic [31:0] MAG     = 32'hC0DE_5A9E;
    localparam logic [63:0] GEN     = 64'h42F0_E1EB_A9EA_3693;
    localparam logic [63:0] MAXV    = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic [63:0] expected_lsn = '0;
    logic        done;
    logic [1:0]  page_class;
    logic [1:0]  repair_action;
    logic        crc_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pic_page_classifier #(.PAGE_WORDS(PW), .MAGIC(MAG)) u0 (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .expected_lsn  (expected_lsn),
        .done          (done),
        .page_class    (page_class),
        .repair_action (repair_action),
        .crc_ok        (crc_ok)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_crc(input logic [63:0] words [PW]);
        logic [63:0] r;
        logic [63:0] w;
        logic        top;
        r = MAXV;
        for (int k = 0; k < PW; k++) begin
            w = (k == 2) ? 64'd0 : words[k];
            for (int b = 63; b >= 0; b--) begin
                top = r[63] ^ w[b];
                r = r << 1;
                if (top) r = r ^ GEN;
            end
        end
        return r;
    endfunction

    // mode: 0 good, 1 checksum damaged, 2 constant wrong
    task automatic run_page(input logic [63:0] st_lsn, input logic [63:0] ex_lsn,
                            input int mode, input logic [31:0] flags,
                            input int seed, input bit gaps);
        logic [63:0] pg [PW];
        logic [63:0] c;
        int          ecls;
        int          eact;
        bit          eok;
        pg[0] = {(mode == 2) ? (MAG ^ 32'h0000_0100) : MAG, flags};
        pg[1] = st_lsn;
        pg[2] = 64'd0;
        for (int k = 3; k < PW; k++)
            pg[k] = 64'h9E37_79B9_7F4A_7C15 * (seed * 13 + k) ^ {32'(seed), 32'(k)};
        c = ref_crc(pg);
        pg[2] = (mode == 1) ? (c ^ (64'd1 << (seed % 64))) : c;
        eok = (mode != 1);
        if (mode != 0)              begin ecls = 3; eact = 2; end
        else if (st_lsn < ex_lsn)   begin ecls = 1; eact = 1; end
        else if (st_lsn == ex_lsn)  begin ecls = 0; eact = 0; end
        else                        begin ecls = 2; eact = 2; end

        for (int k = 0; k < PW; k++) begin
            if (gaps && (k % 2 == 1)) begin
                @(negedge clk);
                in_valid     = 1'b0;
                in_data      = ~pg[k];
                expected_lsn = ~ex_lsn;
                @(posedge clk);
            end
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid     = 1'b1;
            in_data      = pg[k];
            expected_lsn = (k == PW - 1) ? ex_lsn : (ex_lsn ^ 64'h5555_0000_AAAA_0001);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid     = 1'b0;
        in_data      = '0;
        expected_lsn = ~ex_lsn;
        check("R10 done after last word", done, 1);
        check("R2 ready low with done", in_ready, 0);
        check("R5-R9 class", page_class, ecls);
        check("R5-R9 action", repair_action, eact);
        check("R4 crc_ok", crc_ok, eok);
        @(negedge clk);
        check("R10 single pulse", done, 0);
        check("R2 ready back", in_ready, 1);
        check("R10 class held", page_class, ecls);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] st [8];
        logic [63:0] ex [8];
        st[0] = 0;           ex[0] = 0;
        st[1] = 0;           ex[1] = 1;
        st[2] = 1;           ex[2] = 0;
        st[3] = MAXV;        ex[3] = MAXV;
        st[4] = MAXV;        ex[4] = MAXV - 1;
        st[5] = MAXV - 1;    ex[5] = MAXV;
        st[6] = 64'h8000_0000_0000_0000; ex[6] = 64'h7FFF_FFFF_FFFF_FFFF;
        st[7] = 5;           ex[7] = 1000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 done", done, 0);
        check("R1 in_ready", in_ready, 1);
        check("R1 class", page_class, 0);
        check("R1 action", repair_action, 0);
        check("R1 crc_ok", crc_ok, 0);

        // R7 R8 R9 R5 R6 R12 R2 R4: sweep of sequence pairs, damage modes, stalls
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 3; m++) begin
                run_page(st[p], ex[p], m, 32'(p * 7 + m), p * 3 + m, ((p + m) % 2) == 1);
            end
        end

        // R11: flags only change the checksum, not the verdict
        for (int f = 0; f < 4; f++) begin
            run_page(64'd42, 64'd42, 0, {f[7:0], 24'hA5A5A5} ^ 32'hFFFF_0000, 100 + f, 1'b0);
            run_page(64'd42, 64'd41, 0, 32'(f) << 28, 110 + f, 1'b1);
        end

        // R3 R4: many back-to-back good pages with varied bodies (checksum restart)
        for (int s = 0; s < 20; s++) begin
            run_page(64'(s * 1000), 64'(s * 999 + 1), 0, 32'(s), 200 + s, 1'b0);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule